// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block performs lane-wise arithmetic on a 32-bit word. The word is split either into four unsigned 8-bit lanes or into two signed 16-bit fixed-point lanes, which hold fractions between -1 and +1. No carry or borrow passes from one lane to the next. Each lane is computed in its own adder that is wider than the lane. The operations are add and subtract, a left shift, and a right shift. Add, subtract and the left shift each come in a wrapping form and a saturating form. The right shift is logical for bytes and arithmetic for halfwords.

Each lane reports its own overflow flag. The flag is set when the true result does not fit the lane, whether the lane was clamped or wrapped. Saturation follows the lane type. Byte lanes clamp to 0x00 or 0xFF. Halfword lanes clamp to 0x8000 or 0x7FFF. A shift amount comes either from a dedicated immediate port or from the low bits of the second operand, and it is taken modulo the lane width.

A caller presents the operands and the opcode with a valid strobe. The packed result and the overflow flags appear one clock later.

Top module: `simd_sat_alu`

## Requirements
- R1: When `inValid` is sampled high, the result and the overflow flags for that operation appear on `result` and `ovf` after exactly one rising edge. `outValid` repeats `inValid` one cycle later. While `inValid` is low, `result` and `ovf` hold their values. Reset drives `outValid`, `result` and `ovf` to zero.
- R2: Lanes are independent. A carry out of one lane never changes the lane above it.
- R3: In byte mode (`laneMode`=0), opcode 0 adds and opcode 2 subtracts, both modulo 256 per lane. The lane's overflow bit is set on an unsigned carry out (add) or a borrow (subtract).
- R4: In byte mode, opcode 1 (saturating add) clamps an overflowing lane to 0xFF. Opcode 3 (saturating subtract) clamps an underflowing lane to 0x00. Both set the lane's overflow bit.
- R5: In halfword mode (`laneMode`=1), opcodes 0 and 2 add and subtract two's-complement values modulo 65536 per lane. The lane's overflow bit is set when the signed result falls outside -32768..32767.
- R6: In halfword mode, opcodes 1 and 3 clamp a positive overflow to 0x7FFF and a negative overflow to 0x8000, and set the lane's overflow bit.
- R7: In byte mode, opcode 4 (wrapping) and opcode 5 (saturating) shift left by the amount modulo 8. The overflow bit is set when a nonzero bit is shifted out. Opcode 5 then returns 0xFF.
- R8: In halfword mode, opcodes 4 and 5 shift left by the amount modulo 16. The overflow bit is set when the signed value changes. Opcode 5 then returns 0x7FFF for a non-negative lane and 0x8000 for a negative lane.
- R9: Opcode 6 shifts right: logically in byte lanes and arithmetically in halfword lanes. It never sets an overflow bit.
- R10: With `shSrc`=0 the shift amount is `shAmt`. With `shSrc`=1 it is `opB[3:0]`.
- R11: `ovf` bit i belongs to lane i, and lane 0 is the least significant. In halfword mode `ovf[3:2]` is always 0.
- R12: Opcode 7 returns `opA` unchanged with `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand; low 4 bits can serve as a shift amount |
| opCode | input | 3 | Operation: 0 add, 1 add sat, 2 sub, 3 sub sat, 4 shl, 5 shl sat, 6 shr, 7 pass |
| laneMode | input | 1 | 0: four unsigned bytes, 1: two signed halfwords |
| shSrc | input | 1 | Shift amount source: 0 `shAmt`, 1 `opB[3:0]` |
| shAmt | input | 4 | Immediate shift amount |
| outValid | output | 1 | Result of the previous cycle's valid operation is present |
| result | output | 32 | Packed lane results |
| ovf | output | 4 | Per-lane overflow flags |

## Verification
Every result, overflow vector and valid flag is due one rising edge after the cycle in which its inputs were sampled. While no operation is issued, the outputs must stay put. The bench drives inputs on the falling edge. At each following falling edge it compares the outputs with a behavioural model, which holds the value that should have been loaded at the edge in between. Every cycle is checked, including idle cycles, so a wrong latency or a lost hold shows up immediately.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  parameter int WORD_W = 32;
  parameter int SH_W   = 4;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDS = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBS = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHLS = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } opCodeE;

  typedef struct packed {
    logic            loadEn;
    logic            subSel;
    logic            shlSel;
    logic            shrSel;
    logic            passSel;
    logic            satSel;
    logic            halfSel;
    logic [SH_W-1:0] shAmt;
  } laneCtrlT;
endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic            inValid,
  input  logic [2:0]      opCode,
  input  logic            laneMode,
  input  logic            shSrc,
  input  logic [SH_W-1:0] shAmt,
  input  logic [SH_W-1:0] opBLow,
  output laneCtrlT        ctrl
);
  localparam logic [SH_W-1:0] BYTE_MASK = SH_W'((1 << (SH_W - 1)) - 1);

  opCodeE opDec;
  logic [SH_W-1:0] rawAmt;

  always_comb begin
    opDec        = opCodeE'(opCode);
    rawAmt       = shSrc ? opBLow : shAmt;
    ctrl         = '0;
    ctrl.loadEn  = inValid;
    ctrl.halfSel = laneMode;
    ctrl.shAmt   = laneMode ? rawAmt : (rawAmt & BYTE_MASK);
    unique case (opDec)
      OP_ADD:  ctrl.satSel = 1'b0;
      OP_ADDS: ctrl.satSel = 1'b1;
      OP_SUB:  ctrl.subSel = 1'b1;
      OP_SUBS: begin ctrl.subSel = 1'b1; ctrl.satSel = 1'b1; end
      OP_SHL:  ctrl.shlSel = 1'b1;
      OP_SHLS: begin ctrl.shlSel = 1'b1; ctrl.satSel = 1'b1; end
      OP_SHR:  ctrl.shrSel = 1'b1;
      OP_PASS: ctrl.passSel = 1'b1;
      default: ctrl.passSel = 1'b1;
    endcase
  end
endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  laneCtrlT                  ctrl,
  input  logic [WORD_W-1:0]         opA,
  input  logic [WORD_W-1:0]         opB,
  output logic                      outValid,
  output logic [WORD_W-1:0]         result,
  output logic [WORD_W/BYTE_W-1:0]  ovf
);
  localparam int NB  = WORD_W / BYTE_W;
  localparam int NH  = WORD_W / HALF_W;
  localparam int SHB = $clog2(BYTE_W);
  localparam int SHH = $clog2(HALF_W);

  logic [WORD_W-1:0] byteRes, halfRes, nextRes;
  logic [NB-1:0]     byteOvf, nextOvf;
  logic [NH-1:0]     halfOvf;

  // Unsigned byte lanes, each with a private 9-bit adder
  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [BYTE_W-1:0]   a, b, r;
    logic [BYTE_W:0]     sum, dif;
    logic [2*BYTE_W-1:0] shw;
    logic                ov;
    assign a = opA[i*BYTE_W +: BYTE_W];
    assign b = opB[i*BYTE_W +: BYTE_W];
    always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      dif = {1'b0, a} - {1'b0, b};
      shw = {{BYTE_W{1'b0}}, a} << ctrl.shAmt[SHB-1:0];
      r   = a;
      ov  = 1'b0;
      if (ctrl.passSel) begin
        r  = a;
        ov = 1'b0;
      end else if (ctrl.shrSel) begin
        r  = a >> ctrl.shAmt[SHB-1:0];
        ov = 1'b0;
      end else if (ctrl.shlSel) begin
        ov = |shw[2*BYTE_W-1:BYTE_W];
        r  = (ov && ctrl.satSel) ? {BYTE_W{1'b1}} : shw[BYTE_W-1:0];
      end else if (ctrl.subSel) begin
        ov = dif[BYTE_W];
        r  = (ov && ctrl.satSel) ? {BYTE_W{1'b0}} : dif[BYTE_W-1:0];
      end else begin
        ov = sum[BYTE_W];
        r  = (ov && ctrl.satSel) ? {BYTE_W{1'b1}} : sum[BYTE_W-1:0];
      end
    end
    assign byteRes[i*BYTE_W +: BYTE_W] = r;
    assign byteOvf[i] = ov;
  end

  // Signed halfword lanes, each with a private 17-bit adder
  for (genvar j = 0; j < NH; j++) begin : g_half
    localparam logic [HALF_W-1:0] POS_MAX = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] NEG_MIN = {1'b1, {(HALF_W-1){1'b0}}};
    logic [HALF_W-1:0]   a, b, r, clampV;
    logic [HALF_W:0]     sum, dif;
    logic [2*HALF_W-1:0] shw;
    logic                ov;
    assign a = opA[j*HALF_W +: HALF_W];
    assign b = opB[j*HALF_W +: HALF_W];
    always_comb begin
      sum    = {a[HALF_W-1], a} + {b[HALF_W-1], b};
      dif    = {a[HALF_W-1], a} - {b[HALF_W-1], b};
      shw    = {{HALF_W{a[HALF_W-1]}}, a} << ctrl.shAmt[SHH-1:0];
      r      = a;
      ov     = 1'b0;
      clampV = POS_MAX;
      if (ctrl.passSel) begin
        r  = a;
        ov = 1'b0;
      end else if (ctrl.shrSel) begin
        r  = $signed(a) >>> ctrl.shAmt[SHH-1:0];
        ov = 1'b0;
      end else if (ctrl.shlSel) begin
        ov     = shw[2*HALF_W-1:HALF_W-1] != {(HALF_W+1){a[HALF_W-1]}};
        clampV = a[HALF_W-1] ? NEG_MIN : POS_MAX;
        r      = (ov && ctrl.satSel) ? clampV : shw[HALF_W-1:0];
      end else if (ctrl.subSel) begin
        ov     = dif[HALF_W] != dif[HALF_W-1];
        clampV = dif[HALF_W] ? NEG_MIN : POS_MAX;
        r      = (ov && ctrl.satSel) ? clampV : dif[HALF_W-1:0];
      end else begin
        ov     = sum[HALF_W] != sum[HALF_W-1];
        clampV = sum[HALF_W] ? NEG_MIN : POS_MAX;
        r      = (ov && ctrl.satSel) ? clampV : sum[HALF_W-1:0];
      end
    end
    assign halfRes[j*HALF_W +: HALF_W] = r;
    assign halfOvf[j] = ov;
  end

  always_comb begin
    nextRes = ctrl.halfSel ? halfRes : byteRes;
    nextOvf = ctrl.halfSel ? {{(NB-NH){1'b0}}, halfOvf} : byteOvf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      ovf      <= '0;
    end else begin
      outValid <= ctrl.loadEn;
      if (ctrl.loadEn) begin
        result <= nextRes;
        ovf    <= nextOvf;
      end
    end
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [2:0]  opCode,
  input  logic        laneMode,
  input  logic        shSrc,
  input  logic [3:0]  shAmt,
  output logic        outValid,
  output logic [31:0] result,
  output logic [3:0]  ovf
);
  laneCtrlT ctrl;

  simd_alu_ctrl u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .laneMode(laneMode),
    .shSrc   (shSrc),
    .shAmt   (shAmt),
    .opBLow  (opB[SH_W-1:0]),
    .ctrl    (ctrl)
  );

  simd_alu_dp #(.BYTE_W(8), .HALF_W(16)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .opA     (opA),
    .opB     (opB),
    .outValid(outValid),
    .result  (result),
    .ovf     (ovf)
  );
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [2:0]  opCode,
  input logic        laneMode,
  input logic        outValid,
  input logic [31:0] result,
  input logic [3:0]  ovf
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> outValid == $past(inValid));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(inValid)) |-> ($stable(result) && $stable(ovf)));

  p_half_upper_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(inValid) && $past(laneMode)) |-> ovf[3:2] == 2'b00);

  p_shr_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(inValid) && $past(opCode) == 3'd6) |-> ovf == 4'b0000);

  p_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(inValid) && $past(opCode) == 3'd7)
      |-> (result == $past(opA) && ovf == 4'b0000));

  for (genvar i = 0; i < 4; i++) begin : g_bsat
    p_byte_adds_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(inValid && !laneMode && opCode == 3'd1) && ovf[i])
        |-> result[i*8 +: 8] == 8'hFF);
    p_byte_subs_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(inValid && !laneMode && opCode == 3'd3) && ovf[i])
        |-> result[i*8 +: 8] == 8'h00);
  end

  for (genvar j = 0; j < 2; j++) begin : g_hsat
    p_half_clamp_r6: assert property (@(posedge clk) disable iff (!rstN)
      (pastOk && $past(inValid && laneMode && (opCode == 3'd1 || opCode == 3'd3)) && ovf[j])
        |-> (result[j*16 +: 16] == 16'h7FFF || result[j*16 +: 16] == 16'h8000));
  end
endmodule

bind simd_sat_alu simd_sat_alu_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .opCode(opCode), .laneMode(laneMode), .outValid(outValid),
  .result(result), .ovf(ovf)
);

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [2:0]  opCode = '0;
  logic        laneMode = 1'b0, shSrc = 1'b0;
  logic [3:0]  shAmt = '0;
  logic        outValid;
  logic [31:0] result;
  logic [3:0]  ovf;

  int checks = 0, errors = 0;
  logic        expValid = 1'b0;
  logic [31:0] expRes = '0;
  logic [3:0]  expOvf = '0;
  string       expTag = "R1";
  logic        expHalf = 1'b0;

  always #2 clk = ~clk;

  simd_sat_alu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .opCode(opCode), .laneMode(laneMode), .shSrc(shSrc), .shAmt(shAmt),
    .outValid(outValid), .result(result), .ovf(ovf)
  );

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual valid/ovf/result=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic [31:0] b, input int op,
                       input logic half, input int amt,
                       output logic [31:0] r, output logic [3:0] o);
    r = '0; o = '0;
    if (!half) begin
      for (int i = 0; i < 4; i++) begin
        int x, y, s, sh; bit ov;
        x = a[i*8 +: 8]; y = b[i*8 +: 8]; sh = amt % 8; ov = 0; s = x;
        case (op)
          0, 1: begin s = x + y; ov = s > 255; if (ov && op == 1) s = 255; end
          2, 3: begin s = x - y; ov = s < 0;   if (ov && op == 3) s = 0; end
          4, 5: begin s = x * (1 << sh); ov = s > 255; if (ov && op == 5) s = 255; end
          6:    s = x / (1 << sh);
          default: s = x;
        endcase
        r[i*8 +: 8] = s[7:0];
        o[i] = ov;
      end
    end else begin
      for (int j = 0; j < 2; j++) begin
        int x, y, s, sh; bit ov;
        x = $signed(a[j*16 +: 16]); y = $signed(b[j*16 +: 16]); sh = amt % 16; ov = 0; s = x;
        case (op)
          0, 1, 2, 3: begin
            s = (op < 2) ? x + y : x - y;
            ov = (s > 32767) || (s < -32768);
            if (ov && (op == 1 || op == 3)) s = (s > 0) ? 32767 : -32768;
          end
          4, 5: begin
            s = x * (1 << sh);
            ov = (s > 32767) || (s < -32768);
            if (ov && op == 5) s = (x < 0) ? -32768 : 32767;
          end
          6: s = x >>> sh;
          default: s = x;
        endcase
        r[j*16 +: 16] = s[15:0];
        o[j] = ov;
      end
    end
  endtask

  function automatic string reqFor(input int op, input logic half);
    case (op)
      0, 2: return half ? "R5" : "R3";
      1, 3: return half ? "R6" : "R4";
      4, 5: return half ? "R8" : "R7";
      6:    return "R9";
      default: return "R12";
    endcase
  endfunction

  // Compare the outputs due from the previous cycle, then drive the next inputs
  task automatic compareNow();
    check(expTag, {outValid, ovf, result}, {expValid, expOvf, expRes});
    if (expValid && expHalf) check("R11", {33'b0, ovf[3:2]}, 37'b0);
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input int op,
                       input logic half, input logic src, input logic [3:0] amt,
                       input string tag);
    logic [31:0] r; logic [3:0] o;
    @(negedge clk);
    compareNow();
    inValid = 1'b1; opA = a; opB = b; opCode = op[2:0];
    laneMode = half; shSrc = src; shAmt = amt;
    model(a, b, op, half, src ? int'(b[3:0]) : int'(amt), r, o);
    expValid = 1'b1; expRes = r; expOvf = o; expHalf = half;
    expTag = (tag == "") ? reqFor(op, half) : tag;
  endtask

  task automatic idle(input logic [31:0] junk);
    @(negedge clk);
    compareNow();
    inValid = 1'b0; opA = junk; opB = ~junk; opCode = junk[2:0];
    expValid = 1'b0; expHalf = 1'b0; expTag = "R1";
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {outValid, ovf, result}, 37'b0);  // reset state
    rstN = 1'b1;

    // R2: carry out of byte 0 must not reach byte 1
    apply(32'h01FF01FF, 32'h00010001, 0, 0, 0, 0, "R2");
    // R3: wrapping byte add and subtract
    apply(32'h80FF1020, 32'h80023040, 0, 0, 0, 0, "R3");
    apply(32'h00051000, 32'h01060FFF, 2, 0, 0, 0, "R3");
    // R4: saturating byte add and subtract
    apply(32'hF0FF0102, 32'h20010203, 1, 0, 0, 0, "R4");
    apply(32'h00051000, 32'h01060FFF, 3, 0, 0, 0, "R4");
    // R5: wrapping halfword add/sub
    apply(32'h7FFF8000, 32'h0001FFFF, 0, 1, 0, 0, "R5");
    apply(32'h80007FFF, 32'h0001FFFF, 2, 1, 0, 0, "R5");
    // R6: saturating halfword add/sub
    apply(32'h7FFF8000, 32'h0001FFFF, 1, 1, 0, 0, "R6");
    apply(32'h80007FFF, 32'h0001FFFF, 3, 1, 0, 0, "R6");
    // R7: byte shift left, amount 11 acts as 3
    apply(32'h01204080, 32'h0, 4, 0, 0, 4'd11, "R7");
    apply(32'h01204080, 32'h0, 5, 0, 0, 4'd3, "R7");
    // R8: halfword shift left with sign-based clamp
    apply(32'hC0004000, 32'h0, 4, 1, 0, 4'd1, "R8");
    apply(32'hA0002000, 32'h0, 5, 1, 0, 4'd2, "R8");
    // R9: right shifts
    apply(32'h80F00F01, 32'h0, 6, 0, 0, 4'd12, "R9");
    apply(32'h80007FFF, 32'h0, 6, 1, 0, 4'd15, "R9");
    // R10: shift amount from opB
    apply(32'h00010003, 32'h00000002, 4, 1, 1, 4'd9, "R10");
    apply(32'h11223344, 32'hFFFFFF05, 6, 0, 1, 4'd0, "R10");
    // R12: pass-through
    apply(32'hDEADBEEF, 32'h12345678, 7, 1, 0, 4'd0, "R12");
    // R1: outputs hold through idle cycles while inputs change
    idle(32'hA5A5A5A5);
    idle(32'h5A5A5A5A);
    idle(32'h0F0F0F0F);

    for (int k = 0; k < 600; k++) begin
      int op; logic half, src;
      op = $urandom_range(0, 7);
      half = $urandom_range(0, 1);
      src = $urandom_range(0, 1);
      apply($urandom, $urandom, op, half, src, 4'($urandom_range(0, 15)), src ? "R10" : "");
      if ($urandom_range(0, 7) == 0) idle($urandom);
    end
    idle(32'h0);
    idle(32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule